// File: doc/BRIEF.md
# Vectored Priority Interrupt Arbiter

This block collects a set of maskable interrupt sources and one non-maskable software trap, and on request turns them into an even offset into a small vector table. Every maskable source has an enable bit and a pending flag. A source's condition sets its pending flag. The enable bits and the pending flags can be written as whole words and are always visible as outputs. A single global enable bit gates every maskable source. The software trap keeps a pending flag of its own. That flag is held inside the block and does not appear on any port, so the only way to see it is through the vector it produces.

When the processor core executes its vector-lookup instruction, it pulses `vecReq`. One cycle later the block presents `vecOffset` with `vecValid` high. The offset selects a two-byte table entry, and the core uses that entry as the service address. The table spans the even offsets 0xE0 to 0xFE. The trap owns 0xFE, the highest slot. Maskable source i owns 0xE2 + 2·i, so a higher index means higher priority. 0xE0 is the default entry, used when nothing is active. Fetching the instruction and reading the table entry are done outside this block.

Top module: `vec_irq_arbiter`

## Requirements
- R1: While `rstN` is low, all enable bits, all pending flags, the global enable, the trap flag and `vecValid` are 0.
- R2: A 1 on `srcReq[i]` at a clock edge makes `pendingBits[i]` read 1 after that edge. This holds even when a pending-word write in the same cycle would clear that bit.
- R3: `wrEnable` loads `wrData` into `enableBits`, `wrPending` loads it into `pendingBits` (merged with R2), and `gieWrite` loads `gieData` into `gieOut`. Each takes effect at the next edge.
- R4: `vecValid` is 1 in exactly the cycle after a cycle with `vecReq` high, and 0 in every other cycle. `vecOffset` then reflects the state held during the `vecReq` cycle.
- R5: Maskable source i counts as active only when its pending bit, its enable bit and `gieOut` are all 1. The offset for the highest-indexed active source is 0xE2 + 2·i (source 0 gives 0xE2, source 13 gives 0xFC).
- R6: With no active source and the trap flag clear, the offset is 0xE0.
- R7: `trapSet` sets the hidden trap flag. While that flag is set, the offset is 0xFE whatever the enable, pending and global-enable state. The trap flag changes no port other than the offset.
- R8: `trapClr` clears the trap flag. If `trapSet` and `trapClr` come in the same cycle, the flag ends up set.
- R9: A vector request leaves the enable bits, the pending flags and the trap flag unchanged.
- R10: Every presented offset is even and lies in 0xE0 to 0xFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcReq | input | NUM_SRC | Per-source interrupt condition; sets the pending flag |
| wrEnable | input | 1 | Load `wrData` into the enable word |
| wrPending | input | 1 | Load `wrData` into the pending word |
| wrData | input | NUM_SRC | Write data for the enable and pending words |
| gieWrite | input | 1 | Load `gieData` into the global enable |
| gieData | input | 1 | Global enable write value |
| trapSet | input | 1 | Software trap executed; sets the hidden trap flag |
| trapClr | input | 1 | Clears the hidden trap flag |
| vecReq | input | 1 | Vector-lookup strobe |
| enableBits | output | NUM_SRC | Current enable word |
| pendingBits | output | NUM_SRC | Current pending word |
| gieOut | output | 1 | Current global enable |
| vecValid | output | 1 | Offset valid, one cycle after `vecReq` |
| vecOffset | output | 8 | Even vector-table offset |

## Verification
Register writes, pending sets and trap set/clear are all due one edge after the cycle that carries them. The bench drives each stimulus at a falling edge and compares the registered words at the next falling edge. A vector result is due one edge after `vecReq`. The bench therefore computes the expected offset from its model state before that edge and samples `vecValid` and `vecOffset` half a cycle after it. It also confirms that `vecValid` is low in every cycle that did not follow a request.

// File: rtl/vec_irq_arbiter_pkg.sv
package vec_irq_arbiter_pkg;

  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic loadEnable;
    logic loadPending;
    logic loadGie;
    logic trapRaise;
    logic trapDrop;
    logic vecCapture;
  } ctrlStrobes_t;

endpackage

// File: rtl/vec_irq_arbiter_ctrl.sv
module vec_irq_arbiter_ctrl
  import vec_irq_arbiter_pkg::*;
(
  input  logic         wrEnable,
  input  logic         wrPending,
  input  logic         gieWrite,
  input  logic         trapSet,
  input  logic         trapClr,
  input  logic         vecReq,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes.loadEnable  = wrEnable;
    strobes.loadPending = wrPending;
    strobes.loadGie     = gieWrite;
    strobes.trapRaise   = trapSet;
    // A trap raised in the same cycle must not be lost to a clear.
    strobes.trapDrop    = trapClr & ~trapSet;
    strobes.vecCapture  = vecReq;
  end

endmodule

// File: rtl/vec_irq_arbiter_prio.sv
module vec_irq_arbiter_prio #(
  parameter int NUM_SRC = 14,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] active,
  output logic               anyActive,
  output logic [IDX_W-1:0]   winIdx
);

  // aboveAny[i] is 1 when some source with index >= i is active.
  logic [NUM_SRC:0]   aboveAny;
  logic [NUM_SRC-1:0] grant;

  assign aboveAny[NUM_SRC] = 1'b0;

  for (genvar i = NUM_SRC - 1; i >= 0; i--) begin : g_chain
    assign aboveAny[i] = aboveAny[i+1] | active[i];
    assign grant[i]    = active[i] & ~aboveAny[i+1];
  end

  assign anyActive = aboveAny[0];

  always_comb begin
    winIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) winIdx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/vec_irq_arbiter_dp.sv
module vec_irq_arbiter_dp
  import vec_irq_arbiter_pkg::*;
#(
  parameter int         NUM_SRC  = 14,
  parameter logic [7:0] VEC_BASE = 8'hE0,
  localparam int         IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam logic [7:0] TRAP_OFS = VEC_BASE + 8'(2 * (NUM_SRC + 1))
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic               gieData,
  output logic [NUM_SRC-1:0] enableBits,
  output logic [NUM_SRC-1:0] pendingBits,
  output logic               gieOut,
  output logic               trapPending,
  output logic               vecValid,
  output logic [7:0]         vecOffset
);

  logic [NUM_SRC-1:0] enableQ;
  logic [NUM_SRC-1:0] pendingQ;
  logic [NUM_SRC-1:0] pendingNext;
  logic               gieQ;
  logic               trapQ;
  logic               validQ;
  logic [7:0]         offsetQ;

  logic [NUM_SRC-1:0] activeSrc;
  logic               anyActive;
  logic [IDX_W-1:0]   winIdx;
  logic [7:0]         offsetNext;

  // Condition inputs are ORed after the software write so a set wins.
  always_comb begin
    pendingNext = strobes.loadPending ? wrData : pendingQ;
    pendingNext = pendingNext | srcReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ  <= '0;
      pendingQ <= '0;
      gieQ     <= 1'b0;
      trapQ    <= 1'b0;
    end else begin
      if (strobes.loadEnable) enableQ <= wrData;
      pendingQ <= pendingNext;
      if (strobes.loadGie) gieQ <= gieData;
      if (strobes.trapRaise)     trapQ <= 1'b1;
      else if (strobes.trapDrop) trapQ <= 1'b0;
    end
  end

  assign activeSrc = pendingQ & enableQ & {NUM_SRC{gieQ}};

  vec_irq_arbiter_prio #(
    .NUM_SRC(NUM_SRC)
  ) u_prio (
    .active   (activeSrc),
    .anyActive(anyActive),
    .winIdx   (winIdx)
  );

  always_comb begin
    if (trapQ)          offsetNext = TRAP_OFS;
    else if (anyActive) offsetNext = VEC_BASE + 8'd2 + {winIdx, 1'b0};
    else                offsetNext = VEC_BASE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ  <= 1'b0;
      offsetQ <= VEC_BASE;
    end else begin
      validQ <= strobes.vecCapture;
      if (strobes.vecCapture) offsetQ <= offsetNext;
    end
  end

  assign enableBits  = enableQ;
  assign pendingBits = pendingQ;
  assign gieOut      = gieQ;
  assign trapPending = trapQ;
  assign vecValid    = validQ;
  assign vecOffset   = offsetQ;

endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter
  import vec_irq_arbiter_pkg::*;
#(
  parameter int         NUM_SRC  = 14,
  parameter logic [7:0] VEC_BASE = 8'hE0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               wrEnable,
  input  logic               wrPending,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic               gieWrite,
  input  logic               gieData,
  input  logic               trapSet,
  input  logic               trapClr,
  input  logic               vecReq,
  output logic [NUM_SRC-1:0] enableBits,
  output logic [NUM_SRC-1:0] pendingBits,
  output logic               gieOut,
  output logic               vecValid,
  output logic [7:0]         vecOffset
);

  ctrlStrobes_t strobes;
  logic         trapPending;

  vec_irq_arbiter_ctrl u_ctrl (
    .wrEnable (wrEnable),
    .wrPending(wrPending),
    .gieWrite (gieWrite),
    .trapSet  (trapSet),
    .trapClr  (trapClr),
    .vecReq   (vecReq),
    .strobes  (strobes)
  );

  vec_irq_arbiter_dp #(
    .NUM_SRC (NUM_SRC),
    .VEC_BASE(VEC_BASE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .srcReq     (srcReq),
    .wrData     (wrData),
    .gieData    (gieData),
    .enableBits (enableBits),
    .pendingBits(pendingBits),
    .gieOut     (gieOut),
    .trapPending(trapPending),
    .vecValid   (vecValid),
    .vecOffset  (vecOffset)
  );

endmodule

// File: rtl/vec_irq_arbiter_chk.sv
module vec_irq_arbiter_chk #(
  parameter int         NUM_SRC  = 14,
  parameter logic [7:0] VEC_BASE = 8'hE0,
  localparam logic [7:0] TRAP_OFS = VEC_BASE + 8'(2 * (NUM_SRC + 1))
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcReq,
  input logic               wrPending,
  input logic               trapSet,
  input logic               trapClr,
  input logic               vecReq,
  input logic [NUM_SRC-1:0] enableBits,
  input logic [NUM_SRC-1:0] pendingBits,
  input logic               gieOut,
  input logic               vecValid,
  input logic [7:0]         vecOffset,
  input logic               trapPending
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (enableBits == '0 && pendingBits == '0 && !gieOut && !trapPending && !vecValid));

  assert_pend_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (srcReq != '0) |=> ((pendingBits & $past(srcReq)) == $past(srcReq)));

  assert_vec_due_R4: assert property (@(posedge clk) disable iff (!rstN)
    vecReq |=> vecValid);

  assert_vec_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !vecReq |=> !vecValid);

  assert_default_ofs_R6: assert property (@(posedge clk) disable iff (!rstN)
    (vecReq && !trapPending && (!gieOut || (enableBits & pendingBits) == '0))
      |=> (vecOffset == VEC_BASE));

  assert_trap_top_R7: assert property (@(posedge clk) disable iff (!rstN)
    (vecReq && trapPending) |=> (vecOffset == TRAP_OFS));

  assert_trap_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (trapClr && !trapSet) |=> !trapPending);

  assert_trap_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    trapSet |=> trapPending);

  assert_vec_keeps_R9: assert property (@(posedge clk) disable iff (!rstN)
    (vecReq && !wrPending && srcReq == '0) |=> $stable(pendingBits));

  assert_ofs_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (!vecOffset[0] && vecOffset >= VEC_BASE && vecOffset <= TRAP_OFS));

endmodule

bind vec_irq_arbiter vec_irq_arbiter_chk #(
  .NUM_SRC (NUM_SRC),
  .VEC_BASE(VEC_BASE)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .srcReq     (srcReq),
  .wrPending  (wrPending),
  .trapSet    (trapSet),
  .trapClr    (trapClr),
  .vecReq     (vecReq),
  .enableBits (enableBits),
  .pendingBits(pendingBits),
  .gieOut     (gieOut),
  .vecValid   (vecValid),
  .vecOffset  (vecOffset),
  .trapPending(trapPending)
);

// File: tb/vec_irq_arbiter_bench.sv
`timescale 1ns/1ps
module vec_irq_arbiter_bench;

  localparam int N = 14;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] srcReq = '0;
  logic         wrEnable = 1'b0;
  logic         wrPending = 1'b0;
  logic [N-1:0] wrData = '0;
  logic         gieWrite = 1'b0;
  logic         gieData = 1'b0;
  logic         trapSet = 1'b0;
  logic         trapClr = 1'b0;
  logic         vecReq = 1'b0;
  logic [N-1:0] enableBits;
  logic [N-1:0] pendingBits;
  logic         gieOut;
  logic         vecValid;
  logic [7:0]   vecOffset;

  int checks = 0;
  int errors = 0;

  // Bench model of the architectural state.
  logic [N-1:0] mEn = '0;
  logic [N-1:0] mPend = '0;
  logic         mGie = 1'b0;
  logic         mTrap = 1'b0;

  always #5 clk = ~clk;

  vec_irq_arbiter u_vec_irq_arbiter (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .wrEnable(wrEnable),
    .wrPending(wrPending), .wrData(wrData), .gieWrite(gieWrite),
    .gieData(gieData), .trapSet(trapSet), .trapClr(trapClr),
    .vecReq(vecReq), .enableBits(enableBits), .pendingBits(pendingBits),
    .gieOut(gieOut), .vecValid(vecValid), .vecOffset(vecOffset)
  );

  function automatic logic [7:0] expOffset(logic [N-1:0] en, logic [N-1:0] pend,
                                           logic gie, logic trap);
    logic [N-1:0] act;
    if (trap) return 8'hFE;
    act = en & pend & {N{gie}};
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) return 8'hE2 + 8'(2 * i);
    end
    return 8'hE0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, check at the next falling edge.
  task automatic doCycle(logic [N-1:0] req, logic wE, logic wP, logic [N-1:0] data,
                         logic gW, logic gD, logic tS, logic tC, logic vR,
                         string vecTag);
    logic [7:0] expVec;
    string      tag;
    expVec = expOffset(mEn, mPend, mGie, mTrap);
    if (vecTag != "") tag = vecTag;
    else if (mTrap) tag = "R7 trap vector";
    else if ((mEn & mPend & {N{mGie}}) != '0) tag = "R5 priority vector";
    else tag = "R6 default vector";
    srcReq = req; wrEnable = wE; wrPending = wP; wrData = data;
    gieWrite = gW; gieData = gD; trapSet = tS; trapClr = tC; vecReq = vR;
    @(posedge clk);
    if (wE) mEn = data;
    mPend = (wP ? data : mPend) | req;
    if (gW) mGie = gD;
    if (tS) mTrap = 1'b1;
    else if (tC) mTrap = 1'b0;
    @(negedge clk);
    srcReq = '0; wrEnable = 0; wrPending = 0; gieWrite = 0;
    trapSet = 0; trapClr = 0; vecReq = 0;
    check("R2 pending word", 32'(pendingBits), 32'(mPend));
    check("R3 enable word", 32'(enableBits), 32'(mEn));
    check("R3 global enable", 32'(gieOut), 32'(mGie));
    check("R4 valid timing", 32'(vecValid), 32'(vR));
    if (vR) check(tag, 32'(vecOffset), 32'(expVec));
  endtask

  task automatic vecOnly(string tag);
    doCycle('0, 0, 0, '0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 enable reset", 32'(enableBits), 0);
    check("R1 pending reset", 32'(pendingBits), 0);
    check("R1 gie reset", 32'(gieOut), 0);
    check("R1 valid reset", 32'(vecValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: trap cleared by reset -> default vector with nothing active
    vecOnly("R1 trap reset vector");

    // R3: writes, then R5 priority with the top source winning
    doCycle('0, 1, 0, 14'h3FFF, 1, 1, 0, 0, 0, "");
    doCycle('0, 0, 1, 14'h2001, 0, 0, 0, 0, 0, "");
    vecOnly("R5 source 13 over source 0");
    doCycle('0, 0, 1, 14'h0001, 0, 0, 0, 0, 1, "R5 source 13 still pending");
    vecOnly("R5 lowest source 0");
    // R5: enable bit masks a pending source
    doCycle('0, 1, 0, 14'h0000, 0, 0, 0, 0, 1, "R5 enabled before write");
    vecOnly("R6 all masked");
    // R5/R6: global enable masks everything
    doCycle('0, 1, 0, 14'h3FFF, 1, 0, 0, 0, 0, "");
    vecOnly("R6 global enable low");
    doCycle('0, 0, 0, '0, 1, 1, 0, 0, 0, "");
    // R9: repeated requests leave pending untouched
    vecOnly("R9 first request");
    vecOnly("R9 second request");
    // R2: condition beats a clearing pending write in the same cycle
    doCycle(14'h0008, 0, 1, 14'h0000, 0, 0, 0, 0, 0, "");
    check("R2 set beats clear", 32'(pendingBits), 32'h0008);
    vecOnly("R2 source 3 vector");
    // R7: trap wins with global enable low
    doCycle('0, 0, 0, '0, 1, 0, 1, 0, 0, "");
    vecOnly("R7 trap with gie low");
    doCycle('0, 0, 0, '0, 1, 1, 0, 0, 1, "R7 trap over source 3");
    // R8: clear, then set and clear together
    doCycle('0, 0, 0, '0, 0, 0, 0, 1, 0, "");
    vecOnly("R8 trap cleared");
    doCycle('0, 0, 0, '0, 0, 0, 1, 1, 0, "");
    vecOnly("R8 set wins over clear");
    doCycle('0, 0, 0, '0, 0, 0, 0, 1, 0, "");
    // R4: request back to back, then quiet cycle
    vecOnly("R4 back to back a");
    vecOnly("R4 back to back b");
    doCycle('0, 0, 0, '0, 0, 0, 0, 0, 0, "");

    // Random phase
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] rq;
      logic [N-1:0] dt;
      rq = N'($urandom & $urandom & $urandom);
      dt = N'($urandom);
      doCycle(($urandom % 3 == 0) ? rq : '0,
              ($urandom % 8 == 0), ($urandom % 6 == 0), dt,
              ($urandom % 10 == 0), 1'($urandom),
              ($urandom % 25 == 0), ($urandom % 12 == 0),
              ($urandom % 3 == 0), "");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule